// File: doc/BRIEF.md
# Butterfly Weighted Ones Counter

This block counts the ones in an N-bit difference vector, the kind of vector formed by XORing an incoming codeword against a stored one, using nothing but half adders. The half adders are arranged as a butterfly. In each stage, sum bits meet only other sum bits and carry bits meet only other carry bits. Because of this, every output lane has a fixed power-of-two weight, and the weighted sum of the output lanes equals the number of ones at the input. The result is left as weighted bits. A later range decision can read those bits directly, with no binary adder in between.

A parameter selects a reduced, saturating variant for matching against a small detection limit RMAX. Call Pmax the largest power of two that is not above RMAX+1. In the reduced variant, any half adder whose inputs weigh more than Pmax becomes an OR cell. All lanes heavier than Pmax then collapse into a single overflow flag. That flag means the distance is certainly beyond the detection limit. The block is purely combinational. An input width that is not a power of two is padded with constant zeros up to the next power of two, so an unpaired bit passes to the next stage with its weight unchanged.

Top module: `bfly_popcnt`

## Requirements
- R1: Output lane i of `wbit_o` carries the weight 2^popcount(i), where popcount(i) is the number of set bits in the lane index. With SAT_EN=0, the sum of the weights of the set lanes equals the number of ones on `diff_i`. For eight inputs this gives lane 7 weight 8, lanes 3, 5 and 6 weight 4, lanes 1, 2 and 4 weight 2, and lane 0 weight 1.
- R2: When N_BITS is not a power of two, the lanes above N_BITS are fed with zeros. The weighted sum of `wbit_o` is still exact for every input.
- R3: With SAT_EN=0, `ovf_o` is 0 for every input.
- R4: With SAT_EN=1, every lane of `wbit_o` whose weight exceeds Pmax reads 0.
- R5: With SAT_EN=1, any input with at most RMAX+1 ones gives `ovf_o`=0, and the weighted sum of `wbit_o` equals the count.
- R6: With SAT_EN=1, `ovf_o`=1 only when the input holds at least 2·Pmax ones, which is more than RMAX+1.
- R7: With SAT_EN=1 and `ovf_o`=0, the weighted sum of `wbit_o` equals the number of ones on `diff_i`.
- R8: Pmax is the largest power of two that is not above RMAX+1: RMAX=2 gives Pmax=2, and RMAX=4 gives Pmax=4. An all-ones input of width at least 2·Pmax raises `ovf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| diff_i | input | N_BITS | Difference vector whose ones are counted |
| wbit_o | output | LANES (N_BITS rounded up to a power of two) | Weighted output lanes; lane i weighs 2^popcount(i) |
| ovf_o | output | 1 | OR of all lanes heavier than Pmax (reduced variant only) |

## Verification
The bench builds five copies of the block:
- 12 lanes, full counting, which makes every input pattern of a realistic tag width reachable exhaustively;
- 8 lanes, full counting, where the lane weights of the eight-input case are checked bit by bit;
- 5 lanes, full counting, where the zero-padded unpaired paths are exercised;
- 8 lanes, reduced, with RMAX=2;
- 11 lanes, reduced, with RMAX=4.

The two reduced copies use different Pmax values over all of their inputs, so both the boundary between the exact and the merged weights and the case where the flag is cleared at exactly RMAX+1 ones are covered for two detection limits.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // log2 of the weight carried by lane idx: one doubling per set index bit
    function automatic int weight_log(input int idx);
        int n;
        n = 0;
        for (int b = 0; b < 31; b++) begin
            if (((idx >> b) & 1) != 0) n++;
        end
        return n;
    endfunction

    // log2 of the largest power of two not above rmax + 1
    function automatic int pmax_log(input int rmax);
        return $clog2(rmax + 2) - 1;
    endfunction

endpackage

// File: rtl/bfly_cell.sv
module bfly_cell #(
    parameter bit MERGE = 1'b0
) (
    input  logic a_i,
    input  logic b_i,
    output logic lo_o,
    output logic hi_o
);
    generate
        if (MERGE) begin : g_or
            // both inputs already lie above the exact range: only presence matters
            assign lo_o = a_i | b_i;
            assign hi_o = 1'b0;
        end else begin : g_ha
            assign lo_o = a_i ^ b_i;
            assign hi_o = a_i & b_i;
        end
    endgenerate
endmodule

// File: rtl/bfly_stage.sv
module bfly_stage #(
    parameter int LANES    = 16,
    parameter int STAGE    = 0,
    parameter bit SAT_EN   = 1'b0,
    parameter int PMAX_LOG = 1
) (
    input  logic [LANES-1:0] x_i,
    output logic [LANES-1:0] y_o
);
    localparam int SPAN    = 1 << STAGE;
    localparam int LO_MASK = SPAN - 1;

    generate
        for (genvar p = 0; p < LANES / 2; p++) begin : g_pair
            // lane pairs differ only in index bit STAGE, so they hold equal weights
            localparam int IDX_A = ((p >> STAGE) << (STAGE + 1)) | (p & LO_MASK);
            localparam int IDX_B = IDX_A | SPAN;
            localparam bit MERGE = SAT_EN &&
                                   (bfly_pkg::weight_log(IDX_A & LO_MASK) > PMAX_LOG);
            bfly_cell #(.MERGE(MERGE)) u_cell (
                .a_i (x_i[IDX_A]),
                .b_i (x_i[IDX_B]),
                .lo_o(y_o[IDX_A]),
                .hi_o(y_o[IDX_B])
            );
        end
    endgenerate
endmodule

// File: rtl/bfly_ovf_merge.sv
module bfly_ovf_merge #(
    parameter int LANES    = 16,
    parameter bit SAT_EN   = 1'b0,
    parameter int PMAX_LOG = 1
) (
    input  logic [LANES-1:0] lane_i,
    output logic [LANES-1:0] wbit_o,
    output logic             ovf_o
);
    logic [LANES-1:0] heavy;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_mask
            assign heavy[i] = SAT_EN && (bfly_pkg::weight_log(i) > PMAX_LOG);
        end
    endgenerate

    assign wbit_o = lane_i & ~heavy;
    assign ovf_o  = |(lane_i & heavy);
endmodule

// File: rtl/bfly_popcnt.sv
module bfly_popcnt #(
    parameter int  N_BITS = 16,
    parameter bit  SAT_EN = 1'b0,
    parameter int  RMAX   = 2,
    localparam int LANES  = 1 << $clog2(N_BITS)
) (
    input  logic [N_BITS-1:0] diff_i,
    output logic [LANES-1:0]  wbit_o,
    output logic              ovf_o
);
    localparam int STAGES   = $clog2(N_BITS);
    localparam int PMAX_LOG = bfly_pkg::pmax_log(RMAX);

    logic [LANES-1:0] lvl [STAGES+1];

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_pad
            if (i < N_BITS) begin : g_in
                assign lvl[0][i] = diff_i[i];
            end else begin : g_zero
                assign lvl[0][i] = 1'b0;
            end
        end

        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            bfly_stage #(
                .LANES   (LANES),
                .STAGE   (s),
                .SAT_EN  (SAT_EN),
                .PMAX_LOG(PMAX_LOG)
            ) u_stage (
                .x_i(lvl[s]),
                .y_o(lvl[s+1])
            );
        end
    endgenerate

    bfly_ovf_merge #(
        .LANES   (LANES),
        .SAT_EN  (SAT_EN),
        .PMAX_LOG(PMAX_LOG)
    ) u_merge (
        .lane_i(lvl[STAGES]),
        .wbit_o(wbit_o),
        .ovf_o (ovf_o)
    );
endmodule

// File: rtl/bfly_popcnt_chk.sv
module bfly_popcnt_chk #(
    parameter int  N_BITS = 16,
    parameter bit  SAT_EN = 1'b0,
    parameter int  RMAX   = 2,
    localparam int LANES  = 1 << $clog2(N_BITS)
) (
    input logic [N_BITS-1:0] diff_i,
    input logic [LANES-1:0]  wbit_o,
    input logic              ovf_o
);
    localparam int PMAX = 1 << bfly_pkg::pmax_log(RMAX);

    int ones;
    int wsum;

    always_comb begin
        ones = $countones(diff_i);
        wsum = 0;
        for (int i = 0; i < LANES; i++) begin
            if (wbit_o[i]) wsum += (1 << bfly_pkg::weight_log(i));
        end
    end

    always_comb begin
        if (!SAT_EN) begin
            assert_sum_exact_R1: assert (wsum == ones)
                else $error("weighted sum %0d differs from ones %0d", wsum, ones);
            assert_flag_idle_R3: assert (!ovf_o)
                else $error("overflow flag set in full counting mode");
        end else begin
            assert_low_range_R5: assert ((ones > RMAX + 1) || (!ovf_o && wsum == ones))
                else $error("small count %0d not reported exactly", ones);
            assert_flag_floor_R6: assert (!ovf_o || ones >= 2 * PMAX)
                else $error("flag raised with only %0d ones", ones);
            assert_clear_exact_R7: assert (ovf_o || wsum == ones)
                else $error("flag clear but sum %0d differs from %0d", wsum, ones);
        end
    end
endmodule

bind bfly_popcnt bfly_popcnt_chk #(
    .N_BITS(N_BITS),
    .SAT_EN(SAT_EN),
    .RMAX  (RMAX)
) u_chk (
    .diff_i(diff_i),
    .wbit_o(wbit_o),
    .ovf_o (ovf_o)
);

// File: tb/bfly_popcnt_test.sv
module bfly_popcnt_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [11:0] in12 = '0;  logic [15:0] w12;  logic f12;
    logic [7:0]  in8  = '0;  logic [7:0]  w8;   logic f8;
    logic [4:0]  in5  = '0;  logic [7:0]  w5;   logic f5;
    logic [7:0]  ins8 = '0;  logic [7:0]  ws8;  logic fs8;
    logic [10:0] ins11 = '0; logic [15:0] ws11; logic fs11;

    bfly_popcnt #(.N_BITS(12)) uut (.diff_i(in12), .wbit_o(w12), .ovf_o(f12));
    bfly_popcnt #(.N_BITS(8))  uut_full8 (.diff_i(in8), .wbit_o(w8), .ovf_o(f8));
    bfly_popcnt #(.N_BITS(5))  uut_odd5 (.diff_i(in5), .wbit_o(w5), .ovf_o(f5));
    bfly_popcnt #(.N_BITS(8), .SAT_EN(1'b1), .RMAX(2))
        uut_sat8 (.diff_i(ins8), .wbit_o(ws8), .ovf_o(fs8));
    bfly_popcnt #(.N_BITS(11), .SAT_EN(1'b1), .RMAX(4))
        uut_sat11 (.diff_i(ins11), .wbit_o(ws11), .ovf_o(fs11));

    typedef struct packed {
        logic [11:0] vec;
        logic [3:0]  cnt;
    } vec_t;

    localparam vec_t TABLE [8] = '{
        '{12'h000, 4'd0},  '{12'hFFF, 4'd12}, '{12'h001, 4'd1}, '{12'h800, 4'd1},
        '{12'hAAA, 4'd6},  '{12'h0F0, 4'd4},  '{12'h7FF, 4'd11}, '{12'h924, 4'd4}
    };

    function automatic int bits_set(input int v);
        int n;
        n = 0;
        for (int b = 0; b < 16; b++) if (((v >> b) & 1) != 0) n++;
        return n;
    endfunction

    function automatic int lane_sum(input logic [15:0] w);
        int s;
        s = 0;
        for (int i = 0; i < 16; i++) if (w[i]) s += (1 << bits_set(i));
        return s;
    endfunction

    function automatic logic [15:0] heavy_mask(input int plog);
        logic [15:0] m;
        for (int i = 0; i < 16; i++) m[i] = (bits_set(i) > plog);
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic sat_checks(input int ones, input int wsum, input logic flag,
                              input logic [15:0] w, input int plog, input int rmax);
        int pmax;
        pmax = 1 << plog;
        // R4: lanes heavier than Pmax are cleared
        check((w & heavy_mask(plog)) == 16'h0, "R4", int'(w & heavy_mask(plog)), 0);
        // R5: small counts are exact and unflagged
        if (ones <= rmax + 1) check(!flag && wsum == ones, "R5", wsum, ones);
        // R6: flag implies at least 2*Pmax ones
        if (flag) check(ones >= 2 * pmax, "R6", ones, 2 * pmax);
        // R7: clear flag implies exact sum
        if (!flag) check(wsum == ones, "R7", wsum, ones);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        // quiescent state: zero input gives no lanes and no flag (R1, R3)
        @(negedge clk);
        check(w12 == 16'h0, "R1", int'(w12), 0);
        check(f12 == 1'b0, "R3", int'(f12), 0);

        // table of directed vectors (R1, R3)
        foreach (TABLE[k]) begin
            @(posedge clk); in12 = TABLE[k].vec;
            @(negedge clk);
            check(lane_sum(w12) == int'(TABLE[k].cnt), "R1", lane_sum(w12), int'(TABLE[k].cnt));
            check(f12 == 1'b0, "R3", int'(f12), 0);
        end

        // exhaustive 12-bit full counting (R1, R3)
        for (int v = 0; v < 4096; v++) begin
            @(posedge clk); in12 = v[11:0];
            @(negedge clk);
            check(lane_sum(w12) == bits_set(v), "R1", lane_sum(w12), bits_set(v));
            if (f12) check(1'b0, "R3", 1, 0);
        end

        // eight-input lane weights (R1)
        @(posedge clk); in8 = 8'hFF; @(negedge clk);
        check(w8 == 8'h80, "R1", int'(w8), 'h80);
        @(posedge clk); in8 = 8'h0F; @(negedge clk);
        check(w8 == 8'h08, "R1", int'(w8), 'h08);
        @(posedge clk); in8 = 8'h03; @(negedge clk);
        check(w8 == 8'h02, "R1", int'(w8), 'h02);
        @(posedge clk); in8 = 8'h01; @(negedge clk);
        check(w8 == 8'h01, "R1", int'(w8), 'h01);

        // odd width with padded lanes (R2)
        for (int v = 0; v < 32; v++) begin
            @(posedge clk); in5 = v[4:0];
            @(negedge clk);
            check(lane_sum({8'h00, w5}) == bits_set(v), "R2", lane_sum({8'h00, w5}), bits_set(v));
            check(f5 == 1'b0, "R3", int'(f5), 0);
        end

        // reduced variant, RMAX=2, Pmax=2 (R4..R7)
        for (int v = 0; v < 256; v++) begin
            @(posedge clk); ins8 = v[7:0];
            @(negedge clk);
            sat_checks(bits_set(v), lane_sum({8'h00, ws8}), fs8, {8'h00, ws8}, 1, 2);
        end
        @(posedge clk); ins8 = 8'hFF; @(negedge clk);
        check(fs8 == 1'b1, "R8", int'(fs8), 1);

        // reduced variant, RMAX=4, Pmax=4 (R4..R7)
        for (int v = 0; v < 2048; v++) begin
            @(posedge clk); ins11 = v[10:0];
            @(negedge clk);
            sat_checks(bits_set(v), lane_sum(ws11), fs11, ws11, 2, 4);
        end
        @(posedge clk); ins11 = 11'h7FF; @(negedge clk);
        check(fs11 == 1'b1, "R8", int'(fs11), 1);
        // R8: seven ones stay below 2*Pmax=8, so no flag
        @(posedge clk); ins11 = 11'h07F; @(negedge clk);
        check(fs11 == 1'b0, "R8", int'(fs11), 0);

        finished = 1'b1;
        report();
        $finish;
    end
endmodule